// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps time of day and a calendar in packed BCD and presents them to software as eight byte registers at the top of an 8K byte address space. A one-cycle tick input marks each second. The live counters sit behind a set of holding registers. On every tick the block advances the counters and copies the result into the holding registers in the same clock cycle, unless software has frozen the holding registers. Software reads and writes only the holding registers.

A control byte carries two freeze bits. The first bit freezes the holding registers so that a multi-byte read is consistent while the counters keep running. The second bit also freezes them so that software can write a new date and time. Clearing that bit transfers the holding registers into the counters. The seconds byte carries an oscillator stop flag, which is set out of reset. The day-of-week byte carries a frequency-test enable flag. Both flags are brought out as pins.

Top module: `cal_regfile`

## Requirements
- R1: Registers decode only where address bits [12:3] are all ones. Offset 0 is control, then seconds (1), minutes (2), hours (3), day of week (4), date (5), month (6) and year (7). `hit` is 1 only for these eight addresses. Elsewhere `rdata` reads 0x00 and a write changes nothing.
- R2: Each byte holds the tens digit in bits [7:4] and the units digit in [3:0]. Seconds and minutes wrap 59→00 and hours wrap 23→00. The carry ripples through all fields within the single clock edge at which the tick is taken.
- R3: Day of week counts 01..07 and goes from 07 to 01 when the hours wrap at midnight.
- R4: Date wraps to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 for month 02. Month 02 has 29 days when the year's BCD value read as decimal is divisible by four, and year 00 counts as such a year.
- R5: Month goes from 12 to 01 after the last day of the month, and at that point the year advances, with 99 going to 00.
- R6: Seconds bit 7 is the stop flag and drives `stop_o`. It is 1 out of reset. While it is 1, ticks leave the counters unchanged. After it is written to 0, the next tick advances the time.
- R7: Day-of-week bit 6 is the frequency-test flag and drives `ft_o`. It is 0 out of reset. Bits not used by a field always read 0: seconds and minutes bit 7 (apart from the stop flag), hours bits [7:6], day-of-week bits [7:3] (apart from bit 6), date bits [7:6] and month bits [7:5].
- R8: Control bit 6 (read freeze) set to 1 holds the registers at offsets 1–7 at their values while ticks keep advancing the counters. After the bit is cleared, the first tick shows the full elapsed count.
- R9: A tick in the same cycle as the write that sets a freeze bit still refreshes the holding registers. The freeze takes effect from the next tick.
- R10: Control bit 7 (load freeze) set to 1 also freezes the holding registers. A control write that turns this bit from 1 to 0 copies offsets 1–7 into the counters. The next tick continues counting from the loaded time.
- R11: The control register reads back the last byte written to it: bit 7 load freeze, bit 6 read freeze, bit 5 sign, bits [4:0] calibration value.
- R12: After reset the eight registers read 00, 80, 00, 00, 01, 01, 01, 00 (control up to year).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| tick | input | 1 | One-cycle pulse once per second |
| rdata | output | 8 | Read data for `addr` (combinational) |
| hit | output | 1 | `addr` selects a clock register |
| stop_o | output | 1 | Oscillator stop flag |
| ft_o | output | 1 | Frequency-test enable flag |

## Verification
The assertions check on every cycle that the stop flag keeps the counters still and that freezing leaves the holding registers untouched while the counters keep moving. They also check that a refresh lands the counter value in the holding registers, that a load copies the holding registers into the counters, and that the counters stay in BCD and calendar range. The month-length table, the leap rule on BCD years, the full carry chain over an hour and at year end, and the address decode can only be shown by the bench. Its sweeps compare every register against a decimal model of the calendar.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NUM_REGS  = 8;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int LANES     = NUM_REGS - 1;

  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SEC  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MIN  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_HOUR = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DOW  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DATE = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MON  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_YEAR = 3'd7;

  localparam int CTRL_LOADF = 7;
  localparam int CTRL_READF = 6;
  localparam int STOP_BIT   = 7;
  localparam int FT_BIT     = 6;

  // Lane k (1..7) sits at bits [8*(k-1) +: 8]: seconds is the low byte.
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_time_t;

  localparam cal_time_t TIME_RESET = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                       dow: 8'h01, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by four: (10*t + u) mod 4 == (2*t + u) mod 4.
  function automatic logic bcd_leap(input logic [7:0] y);
    return y[4] ? (y[1:0] == 2'b10) : (y[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon,
                                           input logic [7:0] year);
    case (mon)
      8'h02:                      return bcd_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] step_field(input logic [7:0] v,
                                             input logic       at_end,
                                             input logic [7:0] first);
    return at_end ? first : bcd_inc(v);
  endfunction

  // Storable bits of each holding lane; flag bits live in their own flops.
  function automatic logic [7:0] lane_mask(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h7F;
      IDX_HOUR, IDX_DATE: return 8'h3F;
      IDX_DOW:          return 8'h07;
      IDX_MON:          return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      load,
  input  cal_time_t load_val,
  output cal_time_t cnt_q,
  output cal_time_t cnt_nxt,
  output logic      day_wrap
);

  logic sec_wrap, min_wrap, month_wrap, new_year;

  always_comb begin
    sec_wrap   = adv && (cnt_q.sec == 8'h59);
    min_wrap   = sec_wrap && (cnt_q.min == 8'h59);
    day_wrap   = min_wrap && (cnt_q.hour == 8'h23);
    month_wrap = day_wrap && (cnt_q.date == last_day(cnt_q.mon, cnt_q.year));
    new_year   = month_wrap && (cnt_q.mon == 8'h12);

    cnt_nxt = cnt_q;
    if (adv)      cnt_nxt.sec  = step_field(cnt_q.sec, sec_wrap, 8'h00);
    if (sec_wrap) cnt_nxt.min  = step_field(cnt_q.min, min_wrap, 8'h00);
    if (min_wrap) cnt_nxt.hour = step_field(cnt_q.hour, day_wrap, 8'h00);
    if (day_wrap) begin
      cnt_nxt.dow  = step_field(cnt_q.dow, cnt_q.dow == 8'h07, 8'h01);
      cnt_nxt.date = step_field(cnt_q.date, month_wrap, 8'h01);
    end
    if (month_wrap) cnt_nxt.mon  = step_field(cnt_q.mon, new_year, 8'h01);
    if (new_year)   cnt_nxt.year = step_field(cnt_q.year, cnt_q.year == 8'h99, 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= TIME_RESET;
    else if (load) cnt_q <= load_val;
    else           cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/cal_shadow.sv
module cal_shadow
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  input  cal_time_t        cnt_nxt,
  output cal_time_t        hold,
  output logic [7:0]       ctrl_q,
  output logic             stop_q,
  output logic             ft_q,
  output logic             halted,
  output logic             refresh,
  output logic             load
);

  logic [7:0] lane_q [LANES];
  logic [7:0] reset_lane [LANES];
  logic [7:0] cnt_lane [LANES];
  logic       ctrl_wr;

  assign ctrl_wr = wr_hit && (idx == IDX_CTRL);
  assign halted  = ctrl_q[CTRL_LOADF] || ctrl_q[CTRL_READF];
  assign refresh = tick && !halted;
  assign load    = ctrl_wr && ctrl_q[CTRL_LOADF] && !wdata[CTRL_LOADF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 8'h00;
    else if (ctrl_wr) ctrl_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      ft_q   <= 1'b0;
    end else if (wr_hit) begin
      if (idx == IDX_SEC) stop_q <= wdata[STOP_BIT];
      if (idx == IDX_DOW) ft_q   <= wdata[FT_BIT];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(g + 1);
    assign reset_lane[g] = TIME_RESET[8*g +: 8];
    assign cnt_lane[g]   = cnt_nxt[8*g +: 8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q[g] <= reset_lane[g];
      else if (wr_hit && (idx == LANE_IDX))
        lane_q[g] <= wdata & lane_mask(LANE_IDX);
      else if (refresh)
        lane_q[g] <= cnt_lane[g];
    end
    assign hold[8*g +: 8] = lane_q[g];
  end

endmodule

// File: rtl/cal_regfile.sv
module cal_regfile
  import cal_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              tick,
  output logic [7:0]        rdata,
  output logic              hit,
  output logic              stop_o,
  output logic              ft_o
);

  logic [IDX_W-1:0] idx;
  logic             wr_hit;
  logic             adv;
  logic             load;
  logic             refresh;
  logic             halted;
  logic             stop_q;
  logic             ft_q;
  logic             day_wrap;
  logic [7:0]       ctrl_q;
  cal_time_t        cnt_q;
  cal_time_t        cnt_nxt;
  cal_time_t        hold;

  assign hit    = &addr[ADDR_W-1:IDX_W];
  assign idx    = addr[IDX_W-1:0];
  assign wr_hit = wr_en && hit;
  assign adv    = tick && !stop_q;

  cal_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load     (load),
    .load_val (hold),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .day_wrap (day_wrap)
  );

  cal_shadow u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_hit  (wr_hit),
    .idx     (idx),
    .wdata   (wdata),
    .cnt_nxt (cnt_nxt),
    .hold    (hold),
    .ctrl_q  (ctrl_q),
    .stop_q  (stop_q),
    .ft_q    (ft_q),
    .halted  (halted),
    .refresh (refresh),
    .load    (load)
  );

  always_comb begin
    rdata = 8'h00;
    if (hit) begin
      case (idx)
        IDX_CTRL: rdata = ctrl_q;
        IDX_SEC:  rdata = {stop_q, hold.sec[6:0]};
        IDX_MIN:  rdata = hold.min;
        IDX_HOUR: rdata = hold.hour;
        IDX_DOW:  rdata = {1'b0, ft_q, hold.dow[5:0]};
        IDX_DATE: rdata = hold.date;
        IDX_MON:  rdata = hold.mon;
        default:  rdata = hold.year;
      endcase
    end
  end

  assign stop_o = stop_q;
  assign ft_o   = ft_q;

endmodule

// File: rtl/cal_regfile_chk.sv
module cal_regfile_chk
  import cal_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             stop_q,
  input logic             halted,
  input logic             load,
  input logic             refresh,
  input logic             adv,
  input logic             wr_hit,
  input logic [IDX_W-1:0] idx,
  input logic             day_wrap,
  input cal_time_t        cnt_q,
  input cal_time_t        hold
);

  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q.sec <= 8'h59) && (cnt_q.min <= 8'h59) && (cnt_q.hour <= 8'h23)
    && (cnt_q.sec[3:0] <= 4'd9) && (cnt_q.min[3:0] <= 4'd9)); // R2

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_wrap && !load && cnt_q.dow == 8'h07) |=> (cnt_q.dow == 8'h01)); // R3

  AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q.date != 8'h00) && (cnt_q.date <= last_day(cnt_q.mon, cnt_q.year))); // R4

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stop_q && !load) |=> $stable(cnt_q)); // R6

  AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && halted && !load) |=> (cnt_q != $past(cnt_q))); // R8

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_hit) |=> $stable(hold)); // R8

  AST_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !(wr_hit && idx != IDX_CTRL)) |=> (hold == cnt_q)); // R9

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(hold))); // R10

endmodule

bind cal_regfile cal_regfile_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .stop_q   (stop_q),
  .halted   (halted),
  .load     (load),
  .refresh  (refresh),
  .adv      (adv),
  .wr_hit   (wr_hit),
  .idx      (idx),
  .day_wrap (day_wrap),
  .cnt_q    (cnt_q),
  .hold     (hold)
);

// File: tb/tb_cal_regfile.sv
module tb_cal_regfile;

  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] A_CTRL = 13'h1FF8;
  localparam logic [12:0] A_SEC  = 13'h1FF9;
  localparam logic [12:0] A_MIN  = 13'h1FFA;
  localparam logic [12:0] A_HOUR = 13'h1FFB;
  localparam logic [12:0] A_DOW  = 13'h1FFC;
  localparam logic [12:0] A_DATE = 13'h1FFD;
  localparam logic [12:0] A_MON  = 13'h1FFE;
  localparam logic [12:0] A_YEAR = 13'h1FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  rdata;
  logic        hit, stop_o, ft_o;

  int nvec = 0, nfail = 0;
  bit done = 1'b0;
  int s, m, h, dw, dt, mo, yr;

  cal_regfile dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .tick(tick), .rdata(rdata), .hit(hit), .stop_o(stop_o), .ft_o(ft_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(input int mo_i, input int yr_i);
    if (mo_i == 2) return (yr_i % 4 == 0) ? 29 : 28;
    if (mo_i == 4 || mo_i == 6 || mo_i == 9 || mo_i == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; dw = (dw % 7) + 1; dt++;
          if (dt > mlen(mo, yr)) begin
            dt = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input int s_i, input int m_i, input int h_i, input int dw_i,
                          input int dt_i, input int mo_i, input int yr_i);
    s = s_i; m = m_i; h = h_i; dw = dw_i; dt = dt_i; mo = mo_i; yr = yr_i;
    wr(A_CTRL, 8'h80);
    wr(A_SEC, bcd(s));  wr(A_MIN, bcd(m));  wr(A_HOUR, bcd(h));
    wr(A_DOW, bcd(dw)); wr(A_DATE, bcd(dt)); wr(A_MON, bcd(mo));
    wr(A_YEAR, bcd(yr));
    wr(A_CTRL, 8'h00);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(A_SEC, d);  chk({tag, " sec"}, d, bcd(s));
    rd(A_MIN, d);  chk({tag, " min"}, d, bcd(m));
    rd(A_HOUR, d); chk({tag, " hour"}, d, bcd(h));
    rd(A_DOW, d);  chk({tag, " dow"}, d, bcd(dw));
    rd(A_DATE, d); chk({tag, " date"}, d, bcd(dt));
    rd(A_MON, d);  chk({tag, " mon"}, d, bcd(mo));
    rd(A_YEAR, d); chk({tag, " year"}, d, bcd(yr));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12: reset image
    rd(A_CTRL, d); chk("R12 ctrl", d, 8'h00);
    rd(A_SEC, d);  chk("R12 sec", d, 8'h80);
    rd(A_MIN, d);  chk("R12 min", d, 8'h00);
    rd(A_HOUR, d); chk("R12 hour", d, 8'h00);
    rd(A_DOW, d);  chk("R12 dow", d, 8'h01);
    rd(A_DATE, d); chk("R12 date", d, 8'h01);
    rd(A_MON, d);  chk("R12 mon", d, 8'h01);
    rd(A_YEAR, d); chk("R12 year", d, 8'h00);
    chk("R6 stop_o reset", {7'd0, stop_o}, 8'h01);
    chk("R7 ft_o reset", {7'd0, ft_o}, 8'h00);

    // R6: stop flag
    tk(); rd(A_SEC, d); chk("R6 stopped tick", d, 8'h80);
    wr(A_SEC, 8'h00); chk("R6 stop_o cleared", {7'd0, stop_o}, 8'h00);
    tk(); rd(A_SEC, d); chk("R6 first count", d, 8'h01);
    wr(A_SEC, 8'h80);
    tk(); rd(A_SEC, d); chk("R6 stopped again", d, 8'h81);
    wr(A_SEC, 8'h00);
    tk(); rd(A_SEC, d); chk("R6 restarted", d, 8'h02);

    // R11: control readback
    wr(A_CTRL, 8'h3A); rd(A_CTRL, d); chk("R11 ctrl 3A", d, 8'h3A);
    wr(A_CTRL, 8'h25); rd(A_CTRL, d); chk("R11 ctrl 25", d, 8'h25);
    wr(A_CTRL, 8'h00);

    // R7: frequency-test flag and zero bits
    wr(A_DOW, 8'hFF); chk("R7 ft_o set", {7'd0, ft_o}, 8'h01);
    rd(A_DOW, d); chk("R7 dow masked", d, 8'h47);
    wr(A_MON, 8'hFF); rd(A_MON, d); chk("R7 mon masked", d, 8'h1F);
    wr(A_HOUR, 8'hFF); rd(A_HOUR, d); chk("R7 hour masked", d, 8'h3F);
    wr(A_MIN, 8'hFF); rd(A_MIN, d); chk("R7 min masked", d, 8'h7F);
    wr(A_DOW, 8'h01); chk("R7 ft_o clear", {7'd0, ft_o}, 8'h00);
    tk(); rd(A_MON, d); chk("R7 refresh restores mon", d, 8'h01);
    rd(A_SEC, d); chk("R7 sec count", d, 8'h03);

    // R1: decode
    wr(13'h1FF7, 8'hFF);
    wr(13'h0FF8, 8'hC0);
    rd(A_CTRL, d); chk("R1 ctrl untouched", d, 8'h00);
    rd(13'h0FF9, d); chk("R1 off-map read", d, 8'h00);
    chk("R1 hit low", {7'd0, hit}, 8'h00);
    rd(13'h1FF7, d); chk("R1 below map read", d, 8'h00);
    rd(A_YEAR, d); chk("R1 hit high", {7'd0, hit}, 8'h01);
    tk(); rd(A_SEC, d); chk("R1 no freeze", d, 8'h04);

    // R2 R3 R5: one full hour up to year end
    set_time(0, 0, 23, 7, 31, 12, 99);
    check_all("R10 load");
    for (int i = 0; i < 3600; i++) begin
      tk(); model_tick();
      rd(A_SEC, d);  chk("R2 sec", d, bcd(s));
      rd(A_MIN, d);  chk("R2 min", d, bcd(m));
      rd(A_HOUR, d); chk("R2 hour", d, bcd(h));
    end
    rd(A_DOW, d);  chk("R3 dow wrap", d, 8'h01);
    rd(A_DATE, d); chk("R5 date", d, 8'h01);
    rd(A_MON, d);  chk("R5 month wrap", d, 8'h01);
    rd(A_YEAR, d); chk("R5 year wrap", d, 8'h00);

    // R4: month ends over every year for February, all months for four years
    for (int y = 0; y < 100; y++) begin
      for (int mm = 1; mm <= 12; mm++) begin
        if (mm == 2 || y < 4) begin
          set_time(59, 59, 23, 2, mlen(mm, y), mm, y);
          tk(); model_tick();
          rd(A_DATE, d); chk("R4 date", d, bcd(dt));
          rd(A_MON, d);  chk("R4 mon", d, bcd(mo));
          rd(A_YEAR, d); chk("R5 year", d, bcd(yr));
        end
      end
      set_time(59, 59, 23, 2, 28, 2, y);
      tk(); model_tick();
      rd(A_DATE, d); chk("R4 feb 28", d, bcd(dt));
    end

    // R8: read freeze
    set_time(10, 20, 5, 3, 15, 6, 50);
    wr(A_CTRL, 8'h40);
    for (int i = 0; i < 5; i++) begin tk(); model_tick(); end
    rd(A_SEC, d); chk("R8 frozen", d, 8'h10);
    wr(A_CTRL, 8'h00);
    rd(A_SEC, d); chk("R8 no refresh before tick", d, 8'h10);
    tk(); model_tick();
    check_all("R8 elapsed");

    // R9: freeze request coinciding with tick
    @(negedge clk);
    addr = A_CTRL; wdata = 8'h40; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    model_tick();
    rd(A_SEC, held); chk("R9 refresh kept", held, bcd(s));
    tk(); model_tick();
    rd(A_SEC, d); chk("R9 frozen after", d, held);
    wr(A_CTRL, 8'h00);
    tk(); model_tick();
    check_all("R9 resumed");

    // R10: load freeze and transfer
    wr(A_CTRL, 8'h80);
    held = bcd(s);
    tk(); model_tick();
    rd(A_SEC, d); chk("R10 frozen", d, held);
    wr(A_SEC, 8'h30); wr(A_MIN, 8'h45);
    wr(A_CTRL, 8'h00);
    rd(A_SEC, d); chk("R10 loaded no tick", d, 8'h30);
    s = 30; m = 45;
    tk(); model_tick();
    check_all("R10 continue");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule